// File: doc/BRIEF.md
# Hopping NCO Phase Controller

This block drives the phase path of a numerically controlled oscillator for one transmit channel. A 32-bit accumulator advances by an active frequency word on every clock, and its upper half, added to an active 16-bit phase offset modulo 2^16, forms the phase word handed to a downstream sine/cosine stage. A 16-bit phase offset covers just under a full turn with a step of π/32768 radians.

New frequency and phase-offset values are written into staging registers and do not take effect immediately. A sync pulse arms two independent 16-bit hold-off counters, one per value, each loaded from its own programmed count. Each counter runs at the master clock, and the staged value is committed when its counter finishes. Several channels that share a sync can therefore hop frequency or step phase on an exactly known cycle. The same sync can also zero the accumulator when a control input enables this.

The block also applies the output level control. A two-bit scale code sets an attenuation of 6, 12, 18 or 24 dB, applied as an arithmetic right shift of a signed sample. At least 6 dB of loss is always present, so I and Q can both reach full scale without overflowing.

Top module: `nco_hop_ctrl`

## Requirements
- R1: After reset the accumulator, the active frequency word, the active offset and both hold-off counts are zero, so `phase_out` reads 0 and stays at 0 while nothing is written.
- R2: Each clock the accumulator adds the active frequency word modulo 2^32. `phase_out` equals the upper 16 accumulator bits plus the active offset, modulo 2^16.
- R3: A write to a staging register has no effect on `phase_out` until that value's hold-off count completes.
- R4: A sync while the frequency hold count H is nonzero loads the frequency counter with H. The staged frequency becomes active at the H-th rising edge after the sync edge, and the accumulator adds it from the following edge on.
- R5: The offset counter behaves in the same way, independently, with its own hold count. The staged offset shows in `phase_out` right after the commit edge.
- R6: A sync while a hold count is zero leaves that counter at zero, and the staged value is not committed.
- R7: A sync that arrives while a counter is still running reloads it, so the commit moves to H edges after the latest sync.
- R8: With `clr_on_sync` high, a sync sets the accumulator to 0 at that edge and no frequency word is added on that edge. With `clr_on_sync` low, a sync leaves the accumulation unchanged.
- R9: `samp_out` equals `samp_in` shifted arithmetically right by `scale_sel`+1 bits: code 0 gives a shift of 1 and code 3 gives a shift of 4. The sign is kept, so -1 stays -1.
- R10: The offset sum wraps: an offset of 0xFFFF added to an upper accumulator half of 0x0001 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Sync pulse: arms the hold-off counters and may clear the accumulator |
| clr_on_sync | input | 1 | When high, a sync zeroes the accumulator |
| freq_wr | input | 1 | Write strobe for the frequency staging register |
| freq_wdata | input | 32 | Staged frequency word |
| freq_hold | input | 16 | Frequency hold-off count |
| offs_wr | input | 1 | Write strobe for the offset staging register |
| offs_wdata | input | 16 | Staged phase offset |
| offs_hold | input | 16 | Offset hold-off count |
| scale_sel | input | 2 | Attenuation code |
| samp_in | input | 16 | Signed sample to attenuate |
| phase_out | output | 16 | Phase word |
| samp_out | output | 16 | Attenuated signed sample |

## Verification
The assertions check on every cycle that the accumulator steps by the active word or clears on sync, that each sync loads the programmed count, that the active values change only on a counter's final cycle, and that the shifted sample keeps its sign. The exact commit cycle after a sync, the restart of a running count, the value left pending by a zero count, and the wrap of the offset sum can only be shown by the bench's scenarios. The bench compares these against its reference model on every clock.

// File: rtl/nco_hop_pkg.sv
package nco_hop_pkg;
   localparam int unsigned ACC_W  = 32;
   localparam int unsigned PH_W   = 16;
   localparam int unsigned CNT_W  = 16;
   localparam int unsigned SMP_W  = 16;
   localparam int unsigned NSTEP  = 4;
   typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/nco_holdoff.sv
module nco_holdoff #(
   parameter int unsigned DW    = 16,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             wr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [CNT_W-1:0] hold_i,
   output logic [DW-1:0]    act_o
);
   logic [DW-1:0]    stage_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fire;

   assign fire = !sync_i && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         cnt_q   <= '0;
         act_o   <= '0;
      end else begin
         if (wr_i)
            stage_q <= wdata_i;
         if (sync_i)
            cnt_q <= hold_i;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
         if (fire)
            act_o <= stage_q;
      end
   end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [ACC_W-1:0] step_i,
   output logic [ACC_W-1:0] acc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_o <= '0;
      else if (clr_i)
         acc_o <= '0;
      else
         acc_o <= acc_o + step_i;
   end
endmodule

// File: rtl/nco_att_shift.sv
module nco_att_shift #(
   parameter int unsigned SMP_W = 16,
   parameter int unsigned NSTEP = 4,
   localparam int unsigned SEL_W = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
   input  logic [SEL_W-1:0]        sel_i,
   input  logic signed [SMP_W-1:0] samp_i,
   output logic signed [SMP_W-1:0] samp_o
);
   logic signed [SMP_W-1:0] tap [NSTEP];

   for (genvar k = 0; k < NSTEP; k++) begin : g_tap
      assign tap[k] = samp_i >>> (k + 1);
   end

   always_comb begin
      samp_o = tap[0];
      for (int j = 0; j < NSTEP; j++)
         if (sel_i == SEL_W'(j))
            samp_o = tap[j];
   end
endmodule

// File: rtl/nco_hop_ctrl.sv
module nco_hop_ctrl
   import nco_hop_pkg::*;
#(
   parameter int unsigned P_ACC_W = ACC_W,
   parameter int unsigned P_PH_W  = PH_W,
   parameter int unsigned P_CNT_W = CNT_W,
   parameter int unsigned P_SMP_W = SMP_W,
   parameter int unsigned P_NSTEP = NSTEP,
   localparam int unsigned SEL_W  = (P_NSTEP > 1) ? $clog2(P_NSTEP) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sync_in,
   input  logic                   clr_on_sync,
   input  logic                   freq_wr,
   input  logic [P_ACC_W-1:0]     freq_wdata,
   input  logic [P_CNT_W-1:0]     freq_hold,
   input  logic                   offs_wr,
   input  logic [P_PH_W-1:0]      offs_wdata,
   input  logic [P_CNT_W-1:0]     offs_hold,
   input  logic [SEL_W-1:0]       scale_sel,
   input  logic signed [P_SMP_W-1:0] samp_in,
   output logic [P_PH_W-1:0]      phase_out,
   output logic signed [P_SMP_W-1:0] samp_out
);
   if (P_ACC_W < P_PH_W) begin : g_bad_acc
      $error("accumulator narrower than phase word");
   end
   if (P_NSTEP < 1 || P_NSTEP >= P_SMP_W) begin : g_bad_step
      $error("attenuation step count out of range");
   end

   logic [P_ACC_W-1:0] freq_act;
   logic [P_PH_W-1:0]  offs_act;
   logic [P_ACC_W-1:0] acc_q;

   nco_holdoff #(.DW(P_ACC_W), .CNT_W(P_CNT_W)) u_freq (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_in), .wr_i(freq_wr),
      .wdata_i(freq_wdata), .hold_i(freq_hold), .act_o(freq_act));

   nco_holdoff #(.DW(P_PH_W), .CNT_W(P_CNT_W)) u_offs (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_in), .wr_i(offs_wr),
      .wdata_i(offs_wdata), .hold_i(offs_hold), .act_o(offs_act));

   nco_phase_acc #(.ACC_W(P_ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr_i(sync_in && clr_on_sync),
      .step_i(freq_act), .acc_o(acc_q));

   assign phase_out = acc_q[P_ACC_W-1 -: P_PH_W] + offs_act;

   nco_att_shift #(.SMP_W(P_SMP_W), .NSTEP(P_NSTEP)) u_att (
      .sel_i(scale_sel), .samp_i(samp_in), .samp_o(samp_out));
endmodule

// File: rtl/nco_hop_chk.sv
module nco_hop_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned PW = 16,
   parameter int unsigned CW = 16,
   parameter int unsigned SW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sync_in,
   input logic          clr_on_sync,
   input logic [CW-1:0] freq_hold,
   input logic [CW-1:0] offs_hold,
   input logic [AW-1:0] acc,
   input logic [AW-1:0] freq_act,
   input logic [PW-1:0] offs_act,
   input logic [CW-1:0] fcnt,
   input logic [CW-1:0] ocnt,
   input logic [SW-1:0] samp_in,
   input logic [SW-1:0] samp_out
);
   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_in && clr_on_sync) |=> acc == $past(acc) + $past(freq_act)); // R2
   AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in && clr_on_sync) |=> acc == '0); // R8
   AST_FREQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sync_in |=> fcnt == $past(freq_hold)); // R4
   AST_OFFS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sync_in |=> ocnt == $past(offs_hold)); // R5
   AST_FREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in || fcnt != CW'(1)) |=> $stable(freq_act)); // R3
   AST_OFFS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in || ocnt != CW'(1)) |=> $stable(offs_act)); // R3
   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      samp_out[SW-1] == samp_in[SW-1]); // R9
endmodule

bind nco_hop_ctrl nco_hop_chk #(.AW(P_ACC_W), .PW(P_PH_W), .CW(P_CNT_W), .SW(P_SMP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .clr_on_sync(clr_on_sync),
   .freq_hold(freq_hold), .offs_hold(offs_hold), .acc(acc_q),
   .freq_act(freq_act), .offs_act(offs_act),
   .fcnt(u_freq.cnt_q), .ocnt(u_offs.cnt_q),
   .samp_in(samp_in), .samp_out(samp_out));

// File: tb/sim_nco_hop_ctrl.sv
module sim_nco_hop_ctrl;
   localparam int CLK_PER = 10;

   logic clk = 0, rst_n = 0, sync_in = 0, clr_on_sync = 0;
   logic freq_wr = 0, offs_wr = 0;
   logic [31:0] freq_wdata = 0;
   logic [15:0] freq_hold = 0, offs_wdata = 0, offs_hold = 0;
   logic [1:0]  scale_sel = 0;
   logic signed [15:0] samp_in = 0;
   logic [15:0] phase_out;
   logic signed [15:0] samp_out;

   int n_chk = 0, n_err = 0;
   string tag = "R1";
   bit done = 0;

   always #(CLK_PER/2) clk = ~clk;

   nco_hop_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .clr_on_sync(clr_on_sync),
      .freq_wr(freq_wr), .freq_wdata(freq_wdata), .freq_hold(freq_hold),
      .offs_wr(offs_wr), .offs_wdata(offs_wdata), .offs_hold(offs_hold),
      .scale_sel(scale_sel), .samp_in(samp_in),
      .phase_out(phase_out), .samp_out(samp_out));

   // behavioural reference model
   longint m_acc = 0, m_fact = 0, m_fstg = 0;
   int m_oact = 0, m_ostg = 0, m_fcnt = 0, m_ocnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_fact = 0; m_fstg = 0;
         m_oact = 0; m_ostg = 0; m_fcnt = 0; m_ocnt = 0;
      end else begin
         if (sync_in && clr_on_sync) m_acc = 0;
         else m_acc = (m_acc + m_fact) % 64'h1_0000_0000;
         if (sync_in) m_fcnt = int'(freq_hold);
         else if (m_fcnt > 0) begin
            if (m_fcnt == 1) m_fact = m_fstg;
            m_fcnt--;
         end
         if (sync_in) m_ocnt = int'(offs_hold);
         else if (m_ocnt > 0) begin
            if (m_ocnt == 1) m_oact = m_ostg;
            m_ocnt--;
         end
         if (freq_wr) m_fstg = longint'(freq_wdata);
         if (offs_wr) m_ostg = int'(offs_wdata);
      end
   end

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic longint exp_samp(logic signed [15:0] s, logic [1:0] sel);
      int v = int'(s);
      int d = 1 << (int'(sel) + 1);
      if (v >= 0) return longint'(v / d);
      return longint'(-((-v + d - 1) / d)) & 64'hFFFF;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         #(CLK_PER/4);
         chk({tag, " phase"}, longint'(phase_out),
             ((m_acc >> 16) + longint'(m_oact)) % 65536);
         chk("R9 sample", longint'(samp_out) & 64'hFFFF, exp_samp(samp_in, scale_sel));
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sync();
      @(negedge clk) sync_in = 1;
      @(negedge clk) sync_in = 0;
   endtask

   task automatic wr_freq(logic [31:0] v);
      @(negedge clk) begin freq_wr = 1; freq_wdata = v; end
      @(negedge clk) freq_wr = 0;
   endtask

   task automatic wr_offs(logic [15:0] v);
      @(negedge clk) begin offs_wr = 1; offs_wdata = v; end
      @(negedge clk) offs_wr = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      #(CLK_PER*3);
      chk("R1 reset phase", longint'(phase_out), 0);
      @(negedge clk) rst_n = 1;
      tag = "R1"; run(5);
      chk("R1 idle phase", longint'(phase_out), 0);

      tag = "R3"; wr_freq(32'h0001_0000); wr_offs(16'h0100); run(5);
      chk("R3 staged no effect", longint'(phase_out), 0);

      tag = "R4"; freq_hold = 16'd4; pulse_sync(); run(10);

      tag = "R6"; freq_hold = 16'd0; wr_freq(32'h0003_0000); pulse_sync(); run(6);

      tag = "R7"; freq_hold = 16'd5; pulse_sync(); run(2); pulse_sync(); run(8);

      tag = "R5"; offs_hold = 16'd3; freq_hold = 16'd0; pulse_sync(); run(6);

      tag = "R10"; wr_offs(16'hFFFF); offs_hold = 16'd1; pulse_sync(); run(4);

      tag = "R8"; wr_freq(32'h0001_0000); offs_hold = 16'd0; freq_hold = 16'd1;
      pulse_sync(); run(3);
      clr_on_sync = 1; freq_hold = 16'd0;
      @(negedge clk) sync_in = 1;
      @(negedge clk) sync_in = 0;
      #1 chk("R8 cleared on sync", longint'(phase_out), 64'hFFFF);
      run(1);
      #1 chk("R10 wrap to zero", longint'(phase_out), 0);
      clr_on_sync = 0; pulse_sync(); run(5);

      tag = "R2"; wr_freq(32'h8765_4321); freq_hold = 16'd2; pulse_sync(); run(20);

      tag = "R9";
      foreach (samp_in[i]) ; // no-op
      for (int s = 0; s < 4; s++) begin
         @(negedge clk) begin scale_sel = 2'(s); samp_in = 16'sh8000; end
         #1 chk("R9 most negative", longint'(samp_out) & 64'hFFFF,
                longint'(16'h8000 >> (s + 1)) | (longint'(16'hFFFF << (15 - s)) & 64'hFFFF));
         @(negedge clk) samp_in = -16'sd1;
         #1 chk("R9 minus one", longint'(samp_out) & 64'hFFFF, 64'hFFFF);
         @(negedge clk) samp_in = 16'sd100;
         #1 chk("R9 positive", longint'(samp_out), longint'(100 >> (s + 1)));
      end
      run(2);
      finish_run();
   end
endmodule